// File: doc/BRIEF.md
# Parallel Code-Flash Programming Sequencer

This block is the parallel programming port of a small on-chip code flash. It takes an address, a data byte, a two-bit operation select, a pair of read-protect bits and an active-low program strobe. It performs four operations: byte programming, whole-array erase, verify read and identification read. A behavioural byte array models the flash cells. Programming and erasing time themselves in clock cycles. The cycle counts are parameters, so a simulation can use short delays.

A byte write starts on the rising edge of the program strobe. While the write is in progress, a ready flag stays low. A read of the address being written returns an inverted copy of the data's top bit, so the host can poll for completion on the data bus. Erase requires the strobe to be held low for a set number of cycles. Erase then sweeps the array to all ones, one byte per cycle. A byte that is no longer blank cannot be returned to a new value until the next erase. Such a write only clears bits and raises a sticky error flag.

Top module: `pflash_prog_seq`

## Requirements
- R1: After reset, `rdy` is 1, `err` is 0 and `dout` is 00h.
- R2: With `mode` = 2'b10, the erase starts once `prog_n` has been sampled low on ERASE_HOLD consecutive clock edges. `rdy` then stays low while every byte is set to FFh, one byte per cycle. After the erase, verify reads return FFh at every address.
- R3: An erase hold of fewer than ERASE_HOLD cycles does nothing. `rdy` stays high and the array contents and `err` are unchanged.
- R4: With `mode` = 2'b01, a rising edge of `prog_n` while `rdy` is high captures `addr` and `din`. `rdy` goes low from the next cycle for exactly WRITE_CYC cycles. After that, the byte reads back as written.
- R5: While a write is in progress, a verify read of the write address returns {~din[7], 7'b0}. Verify reads of any other address return the stored byte.
- R6: A write to a byte that is not FFh stores the old value ANDed with the new one and sets `err`. `err` stays set until an erase starts. After the erase, writing the same byte stores the new value exactly.
- R7: Rising edges of `prog_n` while `rdy` is low are ignored. They start no second write and change no byte.
- R8: With `mode` = 2'b11, `dout` returns 1Eh at address 030h and 51h at 031h. At 032h it returns FFh when HIGH_VOLT = 1 and 05h otherwise. Any other address returns FFh.
- R9: In the other modes, when either bit of `lock` is 1, array reads return 00h. Data polling on the write address (R5) is still reported.
- R10: `dout` is registered. It reflects the `mode`, `addr` and `lock` values sampled on the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Operation: 00 verify, 01 write, 10 erase, 11 identification |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Data byte to program |
| prog_n | input | 1 | Active-low program strobe |
| lock | input | 2 | Read-protect bits, 1 = protected |
| dout | output | 8 | Read data / polling status |
| rdy | output | 1 | 1 = idle, 0 = write or erase in progress |
| err | output | 1 | Sticky flag for a write to a non-blank byte |

## Verification
The properties assume that `mode`, `addr`, `din`, `lock` and `prog_n` change synchronously to `clk`. They also assume that `mode` is stable for the whole time the strobe is low. This is what lets a strobe edge be attributed to a single operation. The bench meets these assumptions by driving every input on the falling clock edge and changing `mode` only while `prog_n` is high. The bench also erases the array before it reads or programs any byte. This is needed because the cell model has no reset, and a blank check before that erase would see unknown contents.

// File: rtl/pflash_pkg.sv
package pflash_pkg;
  typedef enum logic [1:0] {
    OP_VERIFY = 2'b00,
    OP_WRITE  = 2'b01,
    OP_ERASE  = 2'b10,
    OP_IDENT  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_WRITE = 2'b01,
    ST_ERASE = 2'b10
  } st_e;

  localparam logic [7:0] BLANK = 8'hFF;
endpackage

// File: rtl/pflash_array.sv
module pflash_array #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr_a,
  output logic [7:0]        rd_a,
  input  logic [ADDR_W-1:0] addr_b,
  output logic [7:0]        rd_b,
  input  logic              we,
  input  logic [7:0]        wdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cells [DEPTH];

  // cell model: no reset, contents defined only by erase
  always_ff @(posedge clk) begin
    if (we) cells[addr_b] <= wdata;
  end

  always_comb begin
    rd_a = cells[addr_a];
    rd_b = cells[addr_b];
  end
endmodule

// File: rtl/pflash_ctrl.sv
module pflash_ctrl
  import pflash_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int WRITE_CYC  = 32,
  parameter int ERASE_HOLD = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op,
  input  logic              prog_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic [7:0]        rd_a,
  input  logic [7:0]        rd_b,
  output logic [ADDR_W-1:0] mem_baddr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  output logic              wr_busy,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              wr_msb,
  output logic              rdy,
  output logic              err
);
  localparam int WC_W = $clog2(WRITE_CYC + 1);
  localparam int EH_W = $clog2(ERASE_HOLD + 1);
  localparam logic [WC_W-1:0]   WC_LOAD = WC_W'(WRITE_CYC - 1);
  localparam logic [EH_W-1:0]   EH_LAST = EH_W'(ERASE_HOLD - 1);
  localparam logic [ADDR_W-1:0] A_LAST  = {ADDR_W{1'b1}};

  st_e               state_q, state_d;
  logic              strobe_q;
  logic [WC_W-1:0]   wcnt_q, wcnt_d;
  logic [EH_W-1:0]   hcnt_q, hcnt_d;
  logic [ADDR_W-1:0] ecnt_q, ecnt_d;
  logic [ADDR_W-1:0] wa_q, wa_d;
  logic [7:0]        wd_q, wd_d;
  logic              err_q, err_d;
  logic              rise, hold, ld_en;

  always_comb begin
    rise      = prog_n & ~strobe_q;
    hold      = (state_q == ST_IDLE) && (op == OP_ERASE) && !prog_n;
    state_d   = state_q;
    wcnt_d    = wcnt_q;
    hcnt_d    = '0;
    ecnt_d    = ecnt_q;
    err_d     = err_q;
    ld_en     = 1'b0;
    mem_we    = 1'b0;
    mem_wdata = BLANK;
    unique case (state_q)
      ST_IDLE: begin
        if (op == OP_WRITE && rise) begin
          state_d = ST_WRITE;
          wcnt_d  = WC_LOAD;
          ld_en   = 1'b1;
          if (rd_a != BLANK) err_d = 1'b1;
        end else if (hold) begin
          if (hcnt_q == EH_LAST) begin
            state_d = ST_ERASE;
            ecnt_d  = '0;
            err_d   = 1'b0;
          end else begin
            hcnt_d = hcnt_q + EH_W'(1);
          end
        end
      end
      ST_WRITE: begin
        if (wcnt_q == '0) begin
          mem_we    = 1'b1;
          mem_wdata = rd_b & wd_q;
          state_d   = ST_IDLE;
        end else begin
          wcnt_d = wcnt_q - WC_W'(1);
        end
      end
      ST_ERASE: begin
        mem_we = 1'b1;
        if (ecnt_q == A_LAST) state_d = ST_IDLE;
        else                  ecnt_d  = ecnt_q + ADDR_W'(1);
      end
      default: state_d = ST_IDLE;
    endcase
    wa_d = ld_en ? addr : wa_q;
    wd_d = ld_en ? din  : wd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      strobe_q <= 1'b1;
      wcnt_q   <= '0;
      hcnt_q   <= '0;
      ecnt_q   <= '0;
      wa_q     <= '0;
      wd_q     <= '0;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      strobe_q <= prog_n;
      wcnt_q   <= wcnt_d;
      hcnt_q   <= hcnt_d;
      ecnt_q   <= ecnt_d;
      if (ld_en) begin
        wa_q <= wa_d;
        wd_q <= wd_d;
      end
      err_q    <= err_d;
    end
  end

  assign mem_baddr = (state_q == ST_ERASE) ? ecnt_q : wa_q;
  assign wr_busy   = (state_q == ST_WRITE);
  assign wr_addr   = wa_q;
  assign wr_msb    = wd_q[7];
  assign rdy       = (state_q == ST_IDLE);
  assign err       = err_q;
endmodule

// File: rtl/pflash_rdmux.sv
module pflash_rdmux
  import pflash_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter bit HIGH_VOLT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        lock,
  input  logic [7:0]        rd_a,
  input  logic              wr_busy,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_msb,
  output logic [7:0]        dout
);
  localparam logic [7:0] ID_LAST = HIGH_VOLT ? 8'hFF : 8'h05;

  logic [7:0] dout_d;

  always_comb begin
    if (op == OP_IDENT) begin
      if      (addr == ADDR_W'('h30)) dout_d = 8'h1E;
      else if (addr == ADDR_W'('h31)) dout_d = 8'h51;
      else if (addr == ADDR_W'('h32)) dout_d = ID_LAST;
      else                            dout_d = BLANK;
    end else if (wr_busy && addr == wr_addr) begin
      dout_d = {~wr_msb, 7'b0};
    end else if (|lock) begin
      dout_d = 8'h00;
    end else begin
      dout_d = rd_a;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout <= 8'h00;
    else        dout <= dout_d;
  end
endmodule

// File: rtl/pflash_prog_seq.sv
module pflash_prog_seq
  import pflash_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int WRITE_CYC  = 32,
  parameter int ERASE_HOLD = 40,
  parameter bit HIGH_VOLT  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic              prog_n,
  input  logic [1:0]        lock,
  output logic [7:0]        dout,
  output logic              rdy,
  output logic              err
);
  op_e               op;
  logic [7:0]        rd_a, rd_b, mem_wdata;
  logic [ADDR_W-1:0] mem_baddr, wr_addr;
  logic              mem_we, wr_busy, wr_msb;

  assign op = op_e'(mode);

  pflash_array #(.ADDR_W(ADDR_W)) u_array (
    .clk    (clk),
    .addr_a (addr),
    .rd_a   (rd_a),
    .addr_b (mem_baddr),
    .rd_b   (rd_b),
    .we     (mem_we),
    .wdata  (mem_wdata)
  );

  pflash_ctrl #(
    .ADDR_W     (ADDR_W),
    .WRITE_CYC  (WRITE_CYC),
    .ERASE_HOLD (ERASE_HOLD)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .prog_n    (prog_n),
    .addr      (addr),
    .din       (din),
    .rd_a      (rd_a),
    .rd_b      (rd_b),
    .mem_baddr (mem_baddr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .wr_busy   (wr_busy),
    .wr_addr   (wr_addr),
    .wr_msb    (wr_msb),
    .rdy       (rdy),
    .err       (err)
  );

  pflash_rdmux #(.ADDR_W(ADDR_W), .HIGH_VOLT(HIGH_VOLT)) u_rdmux (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (op),
    .addr    (addr),
    .lock    (lock),
    .rd_a    (rd_a),
    .wr_busy (wr_busy),
    .wr_addr (wr_addr),
    .wr_msb  (wr_msb),
    .dout    (dout)
  );
endmodule

// File: rtl/pflash_prog_seq_chk.sv
module pflash_prog_seq_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode,
  input logic [ADDR_W-1:0] addr,
  input logic              prog_n,
  input logic [1:0]        lock,
  input logic [7:0]        dout,
  input logic              rdy,
  input logic              err
);
  // R4: strobe rise in write mode while idle starts a write
  a_r4_busy_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && rdy && prog_n && !$past(prog_n)) |=> !rdy);

  // R7: once busy, stays busy for more than one cycle
  a_r7_busy_min: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy) |=> !rdy);

  // R2: erase start leaves the error flag clear
  a_r2_erase_clears_err: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rdy) && $past(mode) == 2'b10) |-> !err);

  // R6: error flag only rises when a write launches
  a_r6_err_on_launch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !rdy);

  // R8: first identification byte
  a_r8_ident_first: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11 && addr == ADDR_W'('h30)) |=> dout == 8'h1E);

  // R9: protected reads return zero while idle
  a_r9_lock_hides: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && lock != 2'b00 && rdy) |=> dout == 8'h00);
endmodule

bind pflash_prog_seq pflash_prog_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .mode   (mode),
  .addr   (addr),
  .prog_n (prog_n),
  .lock   (lock),
  .dout   (dout),
  .rdy    (rdy),
  .err    (err)
);

// File: tb/pflash_prog_seq_tb.sv
module pflash_prog_seq_tb;
  localparam int ADDR_W     = 12;
  localparam int WRITE_CYC  = 32;
  localparam int ERASE_HOLD = 40;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [1:0]        mode;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        din;
  logic              prog_n;
  logic [1:0]        lock;
  logic [7:0]        dout;
  logic              rdy, err;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  pflash_prog_seq #(
    .ADDR_W(ADDR_W), .WRITE_CYC(WRITE_CYC), .ERASE_HOLD(ERASE_HOLD), .HIGH_VOLT(1'b1)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .addr(addr), .din(din),
    .prog_n(prog_n), .lock(lock), .dout(dout), .rdy(rdy), .err(err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] m, input logic [ADDR_W-1:0] a,
                    input logic [7:0] exp, input string tag);
    @(negedge clk);
    mode = m;
    addr = a;
    @(negedge clk);
    chk(tag, dout, exp);
  endtask

  task automatic wait_rdy();
    for (int g = 0; g < 10000 && !rdy; g++) @(negedge clk);
  endtask

  task automatic start_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    mode = 2'b01; addr = a; din = d; prog_n = 1'b0;
    @(negedge clk);
    prog_n = 1'b1;
    @(negedge clk);
    mode = 2'b00;
  endtask

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [7:0] d, input string tag);
    int cnt;
    start_write(a, d);
    cnt = rdy ? 0 : 1;
    for (int g = 0; g < 1000 && !rdy; g++) begin
      @(negedge clk);
      if (!rdy) cnt++;
    end
    chk(tag, cnt, WRITE_CYC);
  endtask

  task automatic do_erase();
    @(negedge clk);
    mode = 2'b10; prog_n = 1'b0;
    repeat (ERASE_HOLD + 1) @(negedge clk);
    chk("R2 erase busy", rdy, 1'b0);
    chk("R2 erase clears err", err, 1'b0);
    prog_n = 1'b1; mode = 2'b00;
    wait_rdy();
    chk("R2 erase done", rdy, 1'b1);
  endtask

  task automatic t_reset();
    chk("R1 rdy", rdy, 1'b1);
    chk("R1 err", err, 1'b0);
    chk("R1 dout", dout, 8'h00);
  endtask

  task automatic t_first_erase();
    do_erase();
    rd(2'b00, 12'h000, 8'hFF, "R2 blank low");
    rd(2'b00, 12'hFFF, 8'hFF, "R2 blank high");
    rd(2'b00, 12'h123, 8'hFF, "R2 blank mid");
  endtask

  task automatic t_write_basic();
    do_write(12'h010, 8'h5A, "R4 busy length");
    chk("R6 no err on blank", err, 1'b0);
    rd(2'b00, 12'h010, 8'h5A, "R4 readback");
    rd(2'b10, 12'h010, 8'h5A, "R10 read in erase mode idle");
  endtask

  task automatic t_poll_and_ignore();
    start_write(12'h020, 8'h33);
    chk("R4 busy after rise", rdy, 1'b0);
    rd(2'b00, 12'h020, 8'h80, "R5 polling bit");
    rd(2'b00, 12'h010, 8'h5A, "R5 other addr");
    // R7: second strobe while busy
    @(negedge clk);
    mode = 2'b01; addr = 12'h021; din = 8'h00; prog_n = 1'b0;
    @(negedge clk);
    prog_n = 1'b1;
    @(negedge clk);
    mode = 2'b00;
    wait_rdy();
    rd(2'b00, 12'h020, 8'h33, "R4 second readback");
    rd(2'b00, 12'h021, 8'hFF, "R7 ignored write");
    chk("R7 no err", err, 1'b0);
    chk("R7 stays idle", rdy, 1'b1);
  endtask

  task automatic t_nonblank();
    do_write(12'h010, 8'hF0, "R6 busy length");
    chk("R6 err set", err, 1'b1);
    rd(2'b00, 12'h010, 8'h50, "R6 AND result");
  endtask

  task automatic t_lock();
    @(negedge clk); lock = 2'b01;
    rd(2'b00, 12'h020, 8'h00, "R9 lock bit0");
    @(negedge clk); lock = 2'b10;
    rd(2'b00, 12'h020, 8'h00, "R9 lock bit1");
    @(negedge clk); lock = 2'b00;
    rd(2'b00, 12'h020, 8'h33, "R9 unlocked");
  endtask

  task automatic t_ident();
    rd(2'b11, 12'h030, 8'h1E, "R8 id0");
    rd(2'b11, 12'h031, 8'h51, "R8 id1");
    rd(2'b11, 12'h032, 8'hFF, "R8 id2");
    rd(2'b11, 12'h033, 8'hFF, "R8 other");
  endtask

  task automatic t_short_erase();
    @(negedge clk);
    mode = 2'b10; prog_n = 1'b0;
    repeat (ERASE_HOLD - 1) @(negedge clk);
    prog_n = 1'b1;
    @(negedge clk);
    chk("R3 rdy stays", rdy, 1'b1);
    repeat (2) @(negedge clk);
    chk("R3 rdy still", rdy, 1'b1);
    chk("R3 err kept", err, 1'b1);
    rd(2'b00, 12'h020, 8'h33, "R3 data kept");
  endtask

  task automatic t_erase_rewrite();
    do_erase();
    rd(2'b00, 12'h010, 8'hFF, "R2 erased 010");
    rd(2'b00, 12'h020, 8'hFF, "R2 erased 020");
    do_write(12'h010, 8'hA5, "R6 rewrite busy");
    chk("R6 no err after erase", err, 1'b0);
    rd(2'b00, 12'h010, 8'hA5, "R6 rewrite value");
  endtask

  initial begin
    #(4 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode = 2'b00; addr = '0; din = '0; prog_n = 1'b1; lock = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_erase();
    t_write_basic();
    t_poll_and_ignore();
    t_nonblank();
    t_lock();
    t_ident();
    t_short_erase();
    t_erase_rewrite();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule